// File: doc/BRIEF.md
# Multiplexed Address/Data Asynchronous Bus Master

This block sits on the host side of an asynchronous parallel bus whose address and data travel over one shared set of pins. It runs one single-word read or write per request. A request carries an address, write data and a direction flag. The block then produces the four active-low strobes: chip enable, address valid, output enable and write enable. It drives or floats the shared pins in step with those strobes. When the access is over it returns the read data together with a one-cycle done pulse.

Every access starts with an address phase. In this phase the address is on the pins and the address-valid strobe is low. A short hold phase follows with the strobe high. After that comes either an output-enable phase, with the pins floated, or a write-strobe phase, with the data driven. A recovery phase then ends the access. The length of each phase is a parameter in clock cycles. By default each length is derived from the bus's nanosecond limits at a 10 ns clock (parameter CLK_PS = 10000), each limit rounded up to whole cycles. The pins are modelled as a separate output, output-enable and input, so the tristate pad itself lives outside the block.

Top module: `admux_master`

## Requirements
- R1: After reset, bus_ce_n, bus_adv_n, bus_oe_n and bus_we_n are 1, bus_oe is 0, and busy and done are 0.
- R2: A request is accepted at a clock edge where busy is 0 and req_valid is 1. For the next N_AL cycles (default 1), bus_ce_n and bus_adv_n are 0 and bus_out carries req_addr with bus_oe at 1. For the following N_AH cycles (default 1), bus_adv_n is 1 while bus_ce_n stays 0 and the address is still driven.
- R3: On a read (req_write 0), bus_oe_n is 0 for N_OE cycles (default 3) and bus_oe is 0 throughout. rd_data takes the value of bus_in sampled at the clock edge that ends the last of those cycles.
- R4: After the read strobe, bus_ce_n is 1 and bus_oe stays 0 for N_RR cycles (default 3) before done. This gives the target time to release the pins.
- R5: On a write (req_write 1), bus_we_n is 0 for N_WP cycles (default 2) with req_wdata driven on bus_out. Then, for N_WH cycles (default 1), bus_we_n is 1, bus_ce_n is 0 and the data stays driven. Then bus_ce_n is 1 with the pins floated for N_WR cycles (default 1).
- R6: busy is 1 from the cycle after acceptance through the last recovery cycle, so a default read lasts 8 busy cycles and a default write 6. done is 1 for exactly one cycle, the one after the last recovery cycle, and in that cycle busy is 0.
- R7: While busy is 1, req_valid is ignored: no extra access runs, and the address and data of the access in progress are unaffected.
- R8: bus_oe_n and bus_we_n are never 0 together. bus_ce_n is 0 whenever any other strobe is 0. bus_oe is never 1 while bus_oe_n is 0.
- R9: A request is accepted in any cycle where busy is 0, including the done cycle, and its address phase begins at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Request strobe, sampled when busy is 0 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | BUS_W | Access address |
| req_wdata | input | BUS_W | Write data |
| busy | output | 1 | High while an access is in progress |
| done | output | 1 | One-cycle pulse at the end of an access |
| rd_data | output | BUS_W | Data captured by the last read |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_adv_n | output | 1 | Address valid, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_out | output | BUS_W | Value driven onto the shared pins |
| bus_oe | output | 1 | 1 when the block drives the shared pins |
| bus_in | input | BUS_W | Value seen on the shared pins |

## Verification
A wrong phase state shows at the strobes within one cycle. It appears as a strobe width that is too short or too long, as chip enable high under an active strobe, or as the pins being driven while output enable is low. A phase-counter error stretches or shortens one strobe and changes the busy length seen at the next done pulse. A stale or mis-captured address or data register shows up on bus_out during the address or write phase of the same access. A capture of the read data on the wrong edge returns the idle pattern of the pins instead of the target's word when done rises.

// File: rtl/admux_pkg.sv
package admux_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_AHOLD, PH_RDOE, PH_RDREC, PH_WRSTB, PH_WRHOLD, PH_WRREC
  } phase_t;

  // whole cycles covering a limit given in picoseconds, never below one
  function automatic int ps2cyc(int lim_ps, int clk_ps);
    int c;
    c = (lim_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // address phase: strobe low width and address setup to its release
  function automatic int al_cycles(int clk_ps);
    return max3(ps2cyc(7500, clk_ps), ps2cyc(5000, clk_ps), 1);
  endfunction

  // hold phase: address hold and release-to-strobe spacing are both 2 ns
  function automatic int ah_cycles(int clk_ps);
    return ps2cyc(2000, clk_ps);
  endfunction

  // read strobe: data valid from strobe, from address and from chip enable
  function automatic int oe_cycles(int clk_ps, int al, int ah);
    int pre;
    pre = (al + ah) * clk_ps;
    return max3(ps2cyc(25000, clk_ps), ps2cyc(32000 - pre, clk_ps),
                ps2cyc(34500 - pre, clk_ps));
  endfunction

  // read recovery: bus release, chip enable high time, full cycle length
  function automatic int rr_cycles(int clk_ps, int al, int ah, int oe);
    return max3(ps2cyc(22500, clk_ps), ps2cyc(10000, clk_ps),
                max3(ps2cyc(54500 - (al + ah + oe) * clk_ps, clk_ps),
                     ps2cyc(15000 - (ah + oe) * clk_ps, clk_ps), 1));
  endfunction

  // write strobe: low width, data setup, address/chip-enable time to release
  function automatic int wp_cycles(int clk_ps, int al, int ah);
    return max3(ps2cyc(20000, clk_ps), ps2cyc(18000, clk_ps),
                ps2cyc(30000 - (al + ah) * clk_ps, clk_ps));
  endfunction

  // write hold: data held after the strobe release
  function automatic int wh_cycles(int clk_ps);
    return ps2cyc(2000, clk_ps);
  endfunction

  // write recovery: chip enable high, strobe high time, address-valid high time
  function automatic int wr_cycles(int clk_ps, int ah, int wp, int wh);
    return max3(ps2cyc(10000, clk_ps), ps2cyc(10000 - wh * clk_ps, clk_ps),
                ps2cyc(15000 - (ah + wp + wh) * clk_ps, clk_ps));
  endfunction

endpackage

// File: rtl/admux_phase_timer.sv
module admux_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/admux_pad_mux.sv
module admux_pad_mux #(
  parameter int BUS_W = 16
) (
  input  logic             sel_addr,
  input  logic             sel_data,
  input  logic [BUS_W-1:0] addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe
);
  always_comb begin
    if (sel_addr)      bus_out = addr;
    else if (sel_data) bus_out = wdata;
    else               bus_out = '0;
  end
  assign bus_oe = sel_addr | sel_data;
endmodule

// File: rtl/admux_sequencer.sv
module admux_sequencer
  import admux_pkg::*;
#(
  parameter int N_AL  = 1,
  parameter int N_AH  = 1,
  parameter int N_OE  = 3,
  parameter int N_RR  = 3,
  parameter int N_WP  = 2,
  parameter int N_WH  = 1,
  parameter int N_WR  = 1,
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic busy,
  output logic accept,
  output logic rd_sample,
  output logic finish,
  output logic ce_n,
  output logic adv_n,
  output logic oe_n,
  output logic we_n,
  output logic sel_addr,
  output logic sel_data
);
  phase_t st, st_nxt;
  logic   is_wr;
  logic   ph_last;
  logic   ph_load;
  logic [CNT_W-1:0] ph_len;

  function automatic logic [CNT_W-1:0] span_m1(phase_t p);
    case (p)
      PH_ADDR:   return CNT_W'(N_AL - 1);
      PH_AHOLD:  return CNT_W'(N_AH - 1);
      PH_RDOE:   return CNT_W'(N_OE - 1);
      PH_RDREC:  return CNT_W'(N_RR - 1);
      PH_WRSTB:  return CNT_W'(N_WP - 1);
      PH_WRHOLD: return CNT_W'(N_WH - 1);
      PH_WRREC:  return CNT_W'(N_WR - 1);
      default:   return '0;
    endcase
  endfunction

  always_comb begin
    st_nxt = st;
    case (st)
      PH_IDLE:   if (req_valid) st_nxt = PH_ADDR;
      PH_ADDR:   if (ph_last)   st_nxt = PH_AHOLD;
      PH_AHOLD:  if (ph_last)   st_nxt = is_wr ? PH_WRSTB : PH_RDOE;
      PH_RDOE:   if (ph_last)   st_nxt = PH_RDREC;
      PH_RDREC:  if (ph_last)   st_nxt = PH_IDLE;
      PH_WRSTB:  if (ph_last)   st_nxt = PH_WRHOLD;
      PH_WRHOLD: if (ph_last)   st_nxt = PH_WRREC;
      PH_WRREC:  if (ph_last)   st_nxt = PH_IDLE;
      default:                  st_nxt = PH_IDLE;
    endcase
  end

  // named events for the datapath and the assertions
  assign accept    = (st == PH_IDLE) && req_valid;
  assign rd_sample = (st == PH_RDOE) && ph_last;
  assign finish    = (st != PH_IDLE) && (st_nxt == PH_IDLE);
  assign busy      = (st != PH_IDLE);
  assign ph_load   = (st_nxt != st);
  assign ph_len    = span_m1(st_nxt);

  admux_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_len), .last(ph_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= PH_IDLE;  is_wr <= 1'b0;
      ce_n <= 1'b1;   adv_n <= 1'b1;  oe_n <= 1'b1;  we_n <= 1'b1;
      sel_addr <= 1'b0; sel_data <= 1'b0;
    end else begin
      st <= st_nxt;
      if (accept) is_wr <= req_write;
      ce_n     <= !(st_nxt inside {PH_ADDR, PH_AHOLD, PH_RDOE, PH_WRSTB, PH_WRHOLD});
      adv_n    <= (st_nxt != PH_ADDR);
      oe_n     <= (st_nxt != PH_RDOE);
      we_n     <= (st_nxt != PH_WRSTB);
      sel_addr <= (st_nxt inside {PH_ADDR, PH_AHOLD});
      sel_data <= (st_nxt inside {PH_WRSTB, PH_WRHOLD});
    end
  end

  // low-run counters for strobe width checks
  int unsigned adv_run, we_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adv_run <= 0; we_run <= 0;
    end else begin
      adv_run <= adv_n ? 0 : adv_run + 1;
      we_run  <= we_n  ? 0 : we_run + 1;
    end
  end

  assert_adv_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adv_n) |-> (adv_run >= N_AL));
  assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_run >= N_WP));
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  assert_ce_frames_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_n || !oe_n || !we_n) |-> !ce_n);
  assert_accept_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!adv_n && !ce_n && busy));
endmodule

// File: rtl/admux_master.sv
module admux_master
  import admux_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int CLK_PS = 10000,
  parameter int N_AL   = al_cycles(CLK_PS),
  parameter int N_AH   = ah_cycles(CLK_PS),
  parameter int N_OE   = oe_cycles(CLK_PS, N_AL, N_AH),
  parameter int N_RR   = rr_cycles(CLK_PS, N_AL, N_AH, N_OE),
  parameter int N_WP   = wp_cycles(CLK_PS, N_AL, N_AH),
  parameter int N_WH   = wh_cycles(CLK_PS),
  parameter int N_WR   = wr_cycles(CLK_PS, N_AH, N_WP, N_WH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             busy,
  output logic             done,
  output logic [BUS_W-1:0] rd_data,
  output logic             bus_ce_n,
  output logic             bus_adv_n,
  output logic             bus_oe_n,
  output logic             bus_we_n,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  input  logic [BUS_W-1:0] bus_in
);
  localparam int N_MAX = max3(max3(N_AL, N_AH, N_OE), max3(N_RR, N_WP, N_WH), N_WR);
  localparam int CNT_W = (N_MAX < 2) ? 1 : $clog2(N_MAX);

  logic accept, rd_sample, finish, sel_addr, sel_data;
  logic [BUS_W-1:0] addr_q, wdata_q;

  admux_sequencer #(
    .N_AL(N_AL), .N_AH(N_AH), .N_OE(N_OE), .N_RR(N_RR),
    .N_WP(N_WP), .N_WH(N_WH), .N_WR(N_WR), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .busy(busy), .accept(accept), .rd_sample(rd_sample), .finish(finish),
    .ce_n(bus_ce_n), .adv_n(bus_adv_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
    .sel_addr(sel_addr), .sel_data(sel_data)
  );

  admux_pad_mux #(.BUS_W(BUS_W)) u_pad (
    .sel_addr(sel_addr), .sel_data(sel_data), .addr(addr_q), .wdata(wdata_q),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0; wdata_q <= '0; rd_data <= '0; done <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_sample) rd_data <= bus_in;
      done <= finish;
    end
  end

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> !bus_oe);
  assert_addr_on_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_adv_n |-> (bus_oe && bus_out == addr_q));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));
  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wdata_q)));
endmodule

// File: tb/admux_master_bench.sv
module admux_master_bench;
  localparam int  W   = 16;
  localparam real TCK = 10.0;  // ns per design cycle at the default rate
  // expected phase lengths, each the governing limit rounded up to cycles
  localparam int E_AL = int'($ceil(7.5 / TCK));
  localparam int E_AH = int'($ceil(2.0 / TCK));
  localparam int E_OE = int'($ceil(25.0 / TCK));
  localparam int E_RR = int'($ceil(22.5 / TCK));
  localparam int E_WP = int'($ceil(20.0 / TCK));
  localparam int E_WH = int'($ceil(2.0 / TCK));
  localparam int E_WR = int'($ceil(10.0 / TCK));
  localparam int E_RD_BUSY = E_AL + E_AH + E_OE + E_RR;
  localparam int E_WR_BUSY = E_AL + E_AH + E_WP + E_WH + E_WR;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [W-1:0] req_addr = '0, req_wdata = '0;
  logic busy, done, bus_ce_n, bus_adv_n, bus_oe_n, bus_we_n, bus_oe;
  logic [W-1:0] rd_data, bus_out, bus_in;

  always #10 clk = ~clk;  // 50 MHz bench clock

  admux_master u_admux_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .bus_ce_n(bus_ce_n), .bus_adv_n(bus_adv_n),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_out(bus_out),
    .bus_oe(bus_oe), .bus_in(bus_in)
  );

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // target model: latches the address, answers reads, captures writes
  function automatic logic [W-1:0] pattern(logic [W-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction
  logic [W-1:0] lat_addr = '0, wcap_addr = '0, wcap_data = '0;
  always @(posedge bus_adv_n) lat_addr = bus_out;
  always @(posedge bus_we_n) begin wcap_addr = lat_addr; wcap_data = bus_out; end
  assign bus_in = !bus_oe_n ? pattern(lat_addr) : 16'hFFFF;

  typedef struct { bit wr; logic [W-1:0] addr; logic [W-1:0] data; } item_t;
  item_t q[$];

  // monitor / scoreboard
  int c_adv = 0, c_oe = 0, c_we = 0, c_rec = 0, c_busy = 0, viol = 0;
  bit p_adv = 0, p_we = 0, p_done = 0;
  always @(negedge clk) if (rst_n) begin
    if (!bus_adv_n) begin
      c_adv++;
      if (q.size() == 0 || !bus_oe || bus_out != q[0].addr) viol++;
    end
    if (p_adv && bus_adv_n && (bus_ce_n || !bus_oe || q.size() == 0 || bus_out != q[0].addr)) viol++;
    if (!bus_oe_n) begin c_oe++; if (bus_oe) viol++; end
    if (!bus_we_n) begin
      c_we++;
      if (q.size() == 0 || !bus_oe || bus_out != q[0].data) viol++;
    end
    if (p_we && bus_we_n && (bus_ce_n || !bus_oe || q.size() == 0 || bus_out != q[0].data)) viol++;
    if ((!bus_adv_n || !bus_oe_n || !bus_we_n) && bus_ce_n) viol++;
    if (!bus_oe_n && !bus_we_n) viol++;
    if (busy && bus_ce_n) begin c_rec++; if (bus_oe) viol++; end
    if (busy) c_busy++;
    chk(!(p_done && done), "R6 done wider than one cycle", done, 0);
    if (done) begin
      chk(!busy, "R6 busy low in done cycle", busy, 0);
      if (q.size() == 0) chk(0, "R7 unexpected access finished", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(c_adv == E_AL, "R2 address phase cycles", c_adv, E_AL);
        chk(viol == 0, "R8 strobe/pin rule violations", viol, 0);
        if (!it.wr) begin
          chk(c_oe == E_OE && c_we == 0, "R3 read strobe cycles", c_oe, E_OE);
          chk(rd_data == pattern(it.addr), "R3 read data", rd_data, pattern(it.addr));
          chk(c_rec == E_RR, "R4 read recovery cycles", c_rec, E_RR);
          chk(c_busy == E_RD_BUSY, "R6 read busy cycles", c_busy, E_RD_BUSY);
        end else begin
          chk(c_we == E_WP && c_oe == 0, "R5 write strobe cycles", c_we, E_WP);
          chk(wcap_data == it.data && wcap_addr == it.addr, "R5 write data at target",
              wcap_data, it.data);
          chk(c_rec == E_WR, "R5 write recovery cycles", c_rec, E_WR);
          chk(c_busy == E_WR_BUSY, "R6 write busy cycles", c_busy, E_WR_BUSY);
        end
      end
      c_adv = 0; c_oe = 0; c_we = 0; c_rec = 0; c_busy = 0; viol = 0;
    end
    p_adv = !bus_adv_n; p_we = !bus_we_n; p_done = done;
  end

  // driver: waits for an idle cycle, presents one request, records it
  task automatic issue(input bit wr, input logic [W-1:0] a, input logic [W-1:0] d);
    item_t it;
    do @(negedge clk); while (busy);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    it.wr = wr; it.addr = a; it.data = d;
    q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0; req_addr = 16'h0BAD; req_wdata = 16'h0BAD;
    chk(!bus_adv_n && !bus_ce_n && busy, "R9 address phase follows acceptance", bus_adv_n, 0);
  endtask

  task automatic poke_while_busy();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'hBEEF; req_wdata = 16'h1111;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_ce_n && bus_adv_n, "R1 ce/adv idle high", {bus_ce_n, bus_adv_n}, 3);
    chk(bus_oe_n && bus_we_n, "R1 oe/we idle high", {bus_oe_n, bus_we_n}, 3);
    chk(!bus_oe, "R1 pins floated", bus_oe, 0);
    chk(!busy && !done, "R1 busy/done low", {busy, done}, 0);
    issue(0, 16'h1234, 16'h0);
    repeat (4) @(negedge clk);               // idle gap
    issue(1, 16'h00F0, 16'hCAFE);
    issue(1, 16'h00F1, 16'h1357);            // back-to-back writes (R9)
    issue(0, 16'h00F1, 16'h0);               // read straight after a write
    issue(0, 16'h4321, 16'h0);
    poke_while_busy();                       // R7: ignored request
    issue(0, 16'hFFFE, 16'h0);
    issue(1, 16'h0000, 16'hFFFF);
    issue(0, 16'h8001, 16'h0);
    while (q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(!busy && bus_ce_n, "R7 no extra access after ignored request", busy, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule